// File: doc/BRIEF.md
# Accumulator-Style 8-bit ALU Unit

This block is the execution core of a small accumulator-style processor. It holds the architectural A, X and Y registers and an 8-bit processor status byte. On each cycle in which `valid` is high, it applies one already-decoded operation to that state, using an operand byte supplied by the surrounding datapath. That operand can be a memory value, an immediate, a pulled stack byte or the stack pointer. The unit drives a result byte for the memory-write path, along with the status byte and the X and Y registers.

Every operation has its own rule for which registers, flags and result output it updates. Anything an operation does not name keeps its value. Outputs are registered, so the effect of an operation is visible one cycle after it is presented. Address generation, fetch, branch targets, stack pointer storage and memory access live outside the unit. Decimal-mode arithmetic belongs to a separate BCD unit, so the decimal flag is only stored here.

Top module: `accum_alu`

## Requirements
- R1: While `rst_n` is low, A, X, Y and `result` are zero and `status` is 8'h22.
- R2: Status bit positions are: carry 0, zero 1, interrupt-disable 2, decimal 3, break 4, constant one 5, overflow 6, negative 7. Status bit 5 reads one at all times. The flag codes are: 37 clears carry, 38 sets carry, 39 clears decimal, 40 sets decimal, 41 clears interrupt-disable, 42 sets interrupt-disable, 43 clears overflow, 44 sets break. Each of these changes only its own bit.
- R3: Load A (code 1) and pull A (code 34) put the operand into A and `result`. Load X (2) and load Y (3) put the operand into X or Y and leave `result` alone. All four set Z to (value==0) and N to value bit 7.
- R4: Add (code 4) forms A+M+C in binary, whatever the decimal flag holds. It writes the low byte to A and `result`, sets C when the sum exceeds 255, and updates Z and N. V is set when A and M share a sign bit and the sum's sign bit differs from it.
- R5: Subtract (code 5) forms A-M-1+C in binary. It writes A and `result`, and sets C when there is no borrow (A+~M+C carries out). Z and N are updated. V follows the rule in R4, applied to A and ~M.
- R6: AND (6), OR (7) and XOR (8) combine A with M. Each writes A and `result` and updates Z and N.
- R7: Shift-left moves bit 7 into C; shift-right moves bit 0 into C. The rotates fill the vacated bit with the old C, and the plain shifts fill it with zero. The accumulator forms write A and `result`. The operand forms write only `result`. Codes: shift-left A 9, shift-left M 10, shift-right A 11, shift-right M 12, rotate-left A 13, rotate-left M 14, rotate-right A 15, rotate-right M 16. All eight update Z and N.
- R8: Compare against A (17), X (18) or Y (19) sets Z and N from reg-M and sets C when reg >= M unsigned. The register and `result` stay unchanged.
- R9: BIT (20) sets Z from (A & M), copies M bit 7 into N and M bit 6 into V. It leaves A, C and `result` unchanged.
- R10: Operand increment (21) and decrement (22) drive `result` with M+1 or M-1. The X/Y increments (INX 23, INY 24) and decrements (DEX 25, DEY 26) change only that register. All six update Z and N.
- R11: Transfers A to X (27), A to Y (28), X to A (29), Y to A (30) and operand to X (31) write the destination and set Z and N from it. None of them changes `result`.
- R12: Status pull (35) and interrupt return (36) load `status` with the operand OR 8'h20.
- R13: Store A (32) and push A (33) drive `result` with A and change nothing else. NOP (0) and codes 45 to 63 change no state.
- R14: An operation's effect appears on the outputs after the first rising edge at which `valid` is high. With `valid` low, every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| valid | input | 1 | Operation presented this cycle |
| op | input | OPW (6) | Decoded operation code |
| operand | input | DW (8) | Memory, immediate, pulled or stack-pointer byte |
| result | output | DW (8) | Registered result byte |
| status | output | 8 | Registered status byte |
| x | output | DW (8) | X register |
| y | output | DW (8) | Y register |

## Verification
The bench builds the unit with its default parameters: DW of 8, OPW of 6 and a reset status of 8'h22. At these values the whole opcode space of 64 codes and every 8-bit operand are reachable, so random codes cover the unused-code range as well as every defined code. Directed cases target the carry and overflow edges: 7F+01, FF+01 and 00-01. They also cover a compare of equal values, BIT on 8'hC0, and a status pull of zero.

// File: rtl/accum_alu.sv
module accum_alu #(
  parameter int DW = 8,
  parameter int OPW = 6,
  parameter logic [7:0] P_RESET = 8'h22
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           valid,
  input  logic [OPW-1:0] op,
  input  logic [DW-1:0]  operand,
  output logic [DW-1:0]  result,
  output logic [7:0]     status,
  output logic [DW-1:0]  x,
  output logic [DW-1:0]  y
);
  localparam int MSB = DW - 1;
  localparam int FC = 0, FZ = 1, FI = 2, FD = 3, FB = 4, FONE = 5, FV = 6, FN = 7;

  localparam logic [OPW-1:0]
    K_NOP = 0,  K_LDA = 1,  K_LDX = 2,  K_LDY = 3,  K_ADD = 4,  K_SUB = 5,
    K_AND = 6,  K_ORA = 7,  K_EOR = 8,  K_SLA = 9,  K_SLM = 10, K_SRA = 11,
    K_SRM = 12, K_RLA = 13, K_RLM = 14, K_RRA = 15, K_RRM = 16, K_CPA = 17,
    K_CPX = 18, K_CPY = 19, K_BIT = 20, K_INM = 21, K_DEM = 22, K_INX = 23,
    K_INY = 24, K_DEX = 25, K_DEY = 26, K_TAX = 27, K_TAY = 28, K_TXA = 29,
    K_TYA = 30, K_TSX = 31, K_STA = 32, K_PHA = 33, K_PLA = 34, K_PLP = 35,
    K_RTI = 36, K_CLC = 37, K_SEC = 38, K_CLD = 39, K_SED = 40, K_CLI = 41,
    K_SEI = 42, K_CLV = 43, K_BRK = 44;

  logic [DW-1:0] a, na, nx, ny, nr;
  logic [7:0]    np;

  function automatic logic [7:0] zn(input logic [7:0] p, input logic [DW-1:0] v);
    logic [7:0] q;
    q = p;
    q[FZ] = (v == '0);
    q[FN] = v[MSB];
    return q;
  endfunction

  logic          is_sub;
  logic [DW-1:0] m_eff;
  logic [DW:0]   sum;
  logic          sum_v;
  assign is_sub = (op == K_SUB);
  assign m_eff  = is_sub ? ~operand : operand;
  assign sum    = {1'b0, a} + {1'b0, m_eff} + {{DW{1'b0}}, status[FC]};
  assign sum_v  = (a[MSB] == m_eff[MSB]) && (sum[MSB] != a[MSB]);

  logic          sh_acc, sh_rot;
  logic [DW-1:0] sh_src, shl, shr;
  assign sh_acc = (op == K_SLA) || (op == K_SRA) || (op == K_RLA) || (op == K_RRA);
  assign sh_rot = (op == K_RLA) || (op == K_RLM) || (op == K_RRA) || (op == K_RRM);
  assign sh_src = sh_acc ? a : operand;
  assign shl    = {sh_src[MSB-1:0], sh_rot & status[FC]};
  assign shr    = {sh_rot & status[FC], sh_src[MSB:1]};

  logic [DW-1:0] cmp_reg, cmp_diff;
  assign cmp_reg  = (op == K_CPX) ? x : (op == K_CPY) ? y : a;
  assign cmp_diff = cmp_reg - operand;

  always_comb begin
    na = a; nx = x; ny = y; nr = result; np = status;
    unique case (op)
      K_LDA, K_PLA: begin na = operand; nr = operand; np = zn(status, operand); end
      K_LDX, K_TSX: begin nx = operand; np = zn(status, operand); end
      K_LDY:        begin ny = operand; np = zn(status, operand); end
      K_ADD, K_SUB: begin
        na = sum[MSB:0]; nr = sum[MSB:0];
        np = zn(status, sum[MSB:0]);
        np[FC] = sum[DW];
        np[FV] = sum_v;
      end
      K_AND: begin na = a & operand; nr = a & operand; np = zn(status, a & operand); end
      K_ORA: begin na = a | operand; nr = a | operand; np = zn(status, a | operand); end
      K_EOR: begin na = a ^ operand; nr = a ^ operand; np = zn(status, a ^ operand); end
      K_SLA, K_SLM, K_RLA, K_RLM: begin
        nr = shl; np = zn(status, shl); np[FC] = sh_src[MSB];
        if (sh_acc) na = shl;
      end
      K_SRA, K_SRM, K_RRA, K_RRM: begin
        nr = shr; np = zn(status, shr); np[FC] = sh_src[0];
        if (sh_acc) na = shr;
      end
      K_CPA, K_CPX, K_CPY: begin
        np = zn(status, cmp_diff); np[FC] = (cmp_reg >= operand);
      end
      K_BIT: begin
        np[FZ] = ((a & operand) == '0);
        np[FN] = operand[MSB];
        np[FV] = operand[MSB-1];
      end
      K_INM: begin nr = operand + 1'b1; np = zn(status, operand + 1'b1); end
      K_DEM: begin nr = operand - 1'b1; np = zn(status, operand - 1'b1); end
      K_INX: begin nx = x + 1'b1; np = zn(status, x + 1'b1); end
      K_INY: begin ny = y + 1'b1; np = zn(status, y + 1'b1); end
      K_DEX: begin nx = x - 1'b1; np = zn(status, x - 1'b1); end
      K_DEY: begin ny = y - 1'b1; np = zn(status, y - 1'b1); end
      K_TAX: begin nx = a; np = zn(status, a); end
      K_TAY: begin ny = a; np = zn(status, a); end
      K_TXA: begin na = x; np = zn(status, x); end
      K_TYA: begin na = y; np = zn(status, y); end
      K_STA, K_PHA: nr = a;
      K_PLP, K_RTI: begin np = operand[7:0]; np[FONE] = 1'b1; end
      K_CLC: np[FC] = 1'b0;
      K_SEC: np[FC] = 1'b1;
      K_CLD: np[FD] = 1'b0;
      K_SED: np[FD] = 1'b1;
      K_CLI: np[FI] = 1'b0;
      K_SEI: np[FI] = 1'b1;
      K_CLV: np[FV] = 1'b0;
      K_BRK: np[FB] = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a <= '0; x <= '0; y <= '0; result <= '0; status <= P_RESET;
    end else if (valid) begin
      a <= na; x <= nx; y <= ny; result <= nr; status <= np;
    end
  end

  assert_one_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    status[FONE] == 1'b1);

  assert_idle_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> $stable(result) && $stable(status) && $stable(x) && $stable(y));

  assert_cmp_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op == K_CPX || op == K_CPY) |=> $stable(x) && $stable(y) && $stable(result));

  assert_inx_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == K_INX |=> x == $past(x) + 1'b1 && $stable(result) && $stable(y));

  assert_pull_status_R12: assert property (@(posedge clk) disable iff (!rst_n)
    valid && (op == K_PLP || op == K_RTI) |=> status == ($past(operand[7:0]) | 8'h20));

  assert_ldx_no_result_R3: assert property (@(posedge clk) disable iff (!rst_n)
    valid && op == K_LDX |=> x == $past(operand) && $stable(result));
endmodule

// File: tb/accum_alu_test.sv
module accum_alu_test;
  logic clk = 0, rst_n = 0, valid = 0;
  logic [5:0] op = 0;
  logic [7:0] operand = 0;
  logic [7:0] result, status, x, y;
  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] mA, mX, mY, mR, mP;

  accum_alu uut (.clk(clk), .rst_n(rst_n), .valid(valid), .op(op), .operand(operand),
                 .result(result), .status(status), .x(x), .y(y));

  always #5 clk = ~clk;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL R14 watchdog expired act=%0d exp<150000", cyc);
      $display("  %0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  function automatic string tag(input int c);
    if (c == 1 || c == 2 || c == 3 || c == 34) return "R3";
    if (c == 4) return "R4";
    if (c == 5) return "R5";
    if (c >= 6 && c <= 8) return "R6";
    if (c >= 9 && c <= 16) return "R7";
    if (c >= 17 && c <= 19) return "R8";
    if (c == 20) return "R9";
    if (c >= 21 && c <= 26) return "R10";
    if (c >= 27 && c <= 31) return "R11";
    if (c == 35 || c == 36) return "R12";
    if (c >= 37 && c <= 44) return "R2";
    return "R13";
  endfunction

  function automatic void setzn(input logic [7:0] v);
    mP[1] = (v == 0); mP[7] = v[7];
  endfunction

  task automatic model(input int c, input logic [7:0] m);
    logic [8:0] s; logic [7:0] t, me;
    case (c)
      1, 34: begin mA = m; mR = m; setzn(m); end
      2, 31: begin mX = m; setzn(m); end
      3: begin mY = m; setzn(m); end
      4, 5: begin
        me = (c == 5) ? ~m : m;
        s = mA + me + mP[0];
        mP[6] = (mA[7] == me[7]) && (s[7] != mA[7]);
        mP[0] = s[8]; mA = s[7:0]; mR = s[7:0]; setzn(s[7:0]);
      end
      6: begin mA = mA & m; mR = mA; setzn(mA); end
      7: begin mA = mA | m; mR = mA; setzn(mA); end
      8: begin mA = mA ^ m; mR = mA; setzn(mA); end
      9, 10, 13, 14: begin
        t = (c == 9 || c == 13) ? mA : m;
        mR = {t[6:0], (c >= 13) ? mP[0] : 1'b0}; mP[0] = t[7]; setzn(mR);
        if (c == 9 || c == 13) mA = mR;
      end
      11, 12, 15, 16: begin
        t = (c == 11 || c == 15) ? mA : m;
        mR = {(c >= 15) ? mP[0] : 1'b0, t[7:1]}; mP[0] = t[0]; setzn(mR);
        if (c == 11 || c == 15) mA = mR;
      end
      17, 18, 19: begin
        t = (c == 17) ? mA : (c == 18) ? mX : mY;
        setzn(t - m); mP[0] = (t >= m);
      end
      20: begin mP[1] = ((mA & m) == 0); mP[7] = m[7]; mP[6] = m[6]; end
      21: begin mR = m + 1; setzn(mR); end
      22: begin mR = m - 1; setzn(mR); end
      23: begin mX = mX + 1; setzn(mX); end
      24: begin mY = mY + 1; setzn(mY); end
      25: begin mX = mX - 1; setzn(mX); end
      26: begin mY = mY - 1; setzn(mY); end
      27: begin mX = mA; setzn(mX); end
      28: begin mY = mA; setzn(mY); end
      29: begin mA = mX; setzn(mA); end
      30: begin mA = mY; setzn(mA); end
      32, 33: mR = mA;
      35, 36: mP = m | 8'h20;
      37: mP[0] = 0; 38: mP[0] = 1;
      39: mP[3] = 0; 40: mP[3] = 1;
      41: mP[2] = 0; 42: mP[2] = 1;
      43: mP[6] = 0; 44: mP[4] = 1;
      default: ;
    endcase
  endtask

  task automatic compare(input string rq);
    checks++;
    if (result !== mR || status !== mP || x !== mX || y !== mY) begin
      fails++;
      $display("FAIL %s act r=%h p=%h x=%h y=%h exp r=%h p=%h x=%h y=%h",
               rq, result, status, x, y, mR, mP, mX, mY);
    end
  endtask

  task automatic run(input bit v, input int c, input logic [7:0] m);
    valid = v; op = c[5:0]; operand = m;
    @(posedge clk);
    if (v) model(c, m);
    @(negedge clk);
    compare(v ? tag(c) : "R14");
  endtask

  initial begin
    void'($urandom(32'h5EED));
    mA = 0; mX = 0; mY = 0; mR = 0; mP = 8'h22;
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1;
    run(1, 0, 8'h00);
    // R4 signed overflow, then carry with zero
    run(1, 1, 8'h7F); run(1, 37, 0); run(1, 4, 8'h01);
    run(1, 1, 8'hFF); run(1, 37, 0); run(1, 4, 8'h01);
    // R5 borrow on 00-01, D flag has no effect
    run(1, 40, 0); run(1, 1, 8'h00); run(1, 38, 0); run(1, 5, 8'h01); run(1, 39, 0);
    // R8 equal compare
    run(1, 2, 8'h40); run(1, 18, 8'h40);
    // R9 BIT with both high bits
    run(1, 1, 8'h0F); run(1, 20, 8'hC0);
    // R12 pulled zero keeps bit 5
    run(1, 35, 8'h00);
    // R13 store A shows A
    run(1, 32, 8'h99);
    // R7 rotate through carry
    run(1, 38, 0); run(1, 15, 0); run(1, 14, 8'h80);
    // R10 wrap
    run(1, 3, 8'hFF); run(1, 24, 0); run(1, 21, 8'hFF);
    // R14 idle holds
    run(0, 23, 8'h55);
    for (int i = 0; i < 20000; i++)
      run(($urandom % 8) != 0, $urandom % 64, 8'($urandom));
    rst_n = 0;
    mA = 0; mX = 0; mY = 0; mR = 0; mP = 8'h22;
    @(posedge clk); @(negedge clk);
    compare("R1");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule